// File: doc/BRIEF.md
# NAND ECC Engine Control and Status Registers

This block is the register front-end of a NAND error-correction engine. A simple 32-bit register bus writes and reads the engine settings. Each write is a single cycle with address, write enable and write data. Reads return data combinationally for the address on the bus. The block holds these settings:

- the engine enable and the correction-strength index;
- the host transfer configuration: incrementing bursts, interleaved or packed layout, memory-to-memory copy, and mapping mode;
- the chunk count;
- the main and spare DMA addresses;
- the transfer direction.

It drives all of these straight to the datapath. Six event pulses from the datapath feed an interrupt status register. Status bits are cleared by writing 1 to them. A status-enable mask gates which events latch, and a separate signal-enable mask gates which latched bits drive the single interrupt line.

A transfer is started by writing the DMA control register with its start bit set. A three-state launch machine tracks the transfer:

- `LS_IDLE` moves to `LS_LAUNCH` on such a write.
- `LS_LAUNCH` lasts one cycle and raises the start pulse to the datapath. It moves to `LS_BUSY`, or back to `LS_IDLE` if the transfer-complete event arrives in that same cycle.
- `LS_BUSY` returns to `LS_IDLE` on the transfer-complete event.

The start bit reads back as 1 in `LS_LAUNCH` and `LS_BUSY`, so it clears itself when the transfer ends. Read-only words report a version number and the packed spare-area layout, both taken from parameters.

Top module: `nand_ecc_csr`

## Requirements
- R1: After reset every writable register, the status register, the launch state, the interrupt output and the start pulse are all zero.
- R2: Offset 0x00 stores the engine enable in bit 0 and a 4-bit strength index in bits 6:3. These drive `eng_en_o` and `strength_o`; all other bits read as 0.
- R3: Offset 0x10 stores four flags: bit 0 selects incrementing bursts, bit 2 interleaved layout, bit 4 memory-to-memory transfer and bit 5 mapping mode. They drive the matching outputs; other bits read as 0.
- R4: Offset 0x30 holds a CNT_W-bit chunk count. Offsets 0x44 and 0x48 hold the 32-bit main and spare DMA addresses. All three read back as written and drive their outputs.
- R5: Event vector bits are: 0 transfer complete, 1 main DMA done, 2 spare DMA done, 3 ECC error, 4 spare timeout, 5 main timeout. Status bit i (offset 0x04) latches on event i only if bit i of the status-enable mask (offset 0x08) is 1. Both masks (0x08 and 0x0C) are 6 bits wide.
- R6: Writing offset 0x04 clears each status bit written as 1 and leaves bits written as 0. An event arriving in the same cycle as its clear keeps the bit set.
- R7: `irq_o` is 1 exactly when some status bit and the same bit of the signal-enable mask (offset 0x0C) are both 1. It follows an enabled event one cycle later.
- R8: From idle, a write to offset 0x40 with bit 31 set raises `start_o` for exactly the next cycle and latches bit 1 as the direction (1 = read from NAND). Bit 31 then reads as 1 until a transfer-complete event.
- R9: While a transfer is active, writes to offset 0x40 produce no start pulse and leave the direction unchanged. From idle, a write with bit 31 clear only updates the direction.
- R10: Offset 0xD0 reads VERSION in bits 31:16 and zero below. Offset 0x28 reads the metadata size in bits 7:0, parity size in bits 15:8, reserved size in bits 23:16 and their sum in bits 31:24. Writes to either offset have no effect.
- R11: Unmapped offsets read as zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_i | input | 6 | Event pulses from the datapath |
| irq_o | output | 1 | Interrupt request |
| eng_en_o | output | 1 | Engine enable |
| strength_o | output | 4 | Correction-strength index |
| burst_incr_o | output | 1 | Incrementing burst select |
| layout_ilv_o | output | 1 | Interleaved layout (0 = packed) |
| mem2mem_o | output | 1 | Memory-to-memory transfer |
| mapping_o | output | 1 | Mapping mode |
| chunk_cnt_o | output | CNT_W | Chunks per launch |
| main_addr_o | output | 32 | Main data DMA address |
| spare_addr_o | output | 32 | Spare data DMA address |
| dma_read_o | output | 1 | Direction, 1 = read from NAND |
| start_o | output | 1 | One-cycle launch pulse |

## Verification
The launch machine is the most likely place for a wrong internal state to hide. If it stays in `LS_LAUNCH` or re-enters it, `start_o` is seen high a second cycle in a row. If it leaves `LS_BUSY` early or late, bit 31 of offset 0x40 reads wrong on the first read after the completion event. A status or mask flop that is stuck or set wrongly shows on `irq_o` and on the read of offset 0x04 one cycle after the event or clear write. A mis-decoded offset shows on the very next read-back of that address, or of an unmapped address.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

    localparam logic [7:0] OFS_CFG       = 8'h00;
    localparam logic [7:0] OFS_STS       = 8'h04;
    localparam logic [7:0] OFS_STS_EN    = 8'h08;
    localparam logic [7:0] OFS_SIG_EN    = 8'h0C;
    localparam logic [7:0] OFS_HOST      = 8'h10;
    localparam logic [7:0] OFS_SPARE_LAY = 8'h28;
    localparam logic [7:0] OFS_CHUNKS    = 8'h30;
    localparam logic [7:0] OFS_DMA_CTL   = 8'h40;
    localparam logic [7:0] OFS_MAIN_ADR  = 8'h44;
    localparam logic [7:0] OFS_SPARE_ADR = 8'h48;
    localparam logic [7:0] OFS_VERSION   = 8'hD0;

    localparam int NUM_EVT   = 6;
    localparam int EV_DONE   = 0;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_STR_LSB = 3;
    localparam int STR_W       = 4;

    localparam int HOST_BURST = 0;
    localparam int HOST_ILV   = 2;
    localparam int HOST_M2M   = 4;
    localparam int HOST_MAP   = 5;

    localparam int DMA_GO_BIT = 31;
    localparam int DMA_RD_BIT = 1;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_LAUNCH = 2'd1,
        LS_BUSY   = 2'd2
    } launch_state_e;

endpackage

// File: rtl/ecc_cfg_bank.sv
module ecc_cfg_bank
    import ecc_regs_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int ADR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_cfg,
    input  logic                     wr_host,
    input  logic                     wr_chunks,
    input  logic [1:0]               wr_adr,
    input  logic [31:0]              wdata,
    output logic                     eng_en,
    output logic [STR_W-1:0]         strength,
    output logic                     burst_incr,
    output logic                     layout_ilv,
    output logic                     mem2mem,
    output logic                     mapping,
    output logic [CNT_W-1:0]         chunk_cnt,
    output logic [1:0][ADR_W-1:0]    adr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_en   <= 1'b0;
            strength <= '0;
        end else if (wr_cfg) begin
            eng_en   <= wdata[CFG_EN_BIT];
            strength <= wdata[CFG_STR_LSB +: STR_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_incr <= 1'b0;
            layout_ilv <= 1'b0;
            mem2mem    <= 1'b0;
            mapping    <= 1'b0;
        end else if (wr_host) begin
            burst_incr <= wdata[HOST_BURST];
            layout_ilv <= wdata[HOST_ILV];
            mem2mem    <= wdata[HOST_M2M];
            mapping    <= wdata[HOST_MAP];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_cnt <= '0;
        end else if (wr_chunks) begin
            chunk_cnt <= wdata[CNT_W-1:0];
        end
    end

    // one address register per DMA stream (0 = main, 1 = spare)
    for (genvar g = 0; g < 2; g++) begin : g_adr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                adr[g] <= '0;
            end else if (wr_adr[g]) begin
                adr[g] <= wdata[ADR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ecc_irq_unit.sv
module ecc_irq_unit
    import ecc_regs_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_sts,
    input  logic         wr_sts_en,
    input  logic         wr_sig_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] sts_o,
    output logic [N-1:0] sts_en_o,
    output logic [N-1:0] sig_en_o,
    output logic         irq_o
);

    logic [N-1:0] sts_q;
    logic [N-1:0] sts_en_q;
    logic [N-1:0] sig_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_en_q <= '0;
            sig_en_q <= '0;
        end else begin
            if (wr_sts_en) sts_en_q <= wdata;
            if (wr_sig_en) sig_en_q <= wdata;
        end
    end

    // per-bit status flop: set beats write-1-to-clear
    for (genvar b = 0; b < N; b++) begin : g_sts
        logic set_b;
        logic clr_b;
        assign set_b = evt_i[b] & sts_en_q[b];
        assign clr_b = wr_sts & wdata[b];
        always_ff @(posedge clk) begin
            if (!rst_n)     sts_q[b] <= 1'b0;
            else if (set_b) sts_q[b] <= 1'b1;
            else if (clr_b) sts_q[b] <= 1'b0;
        end
    end

    assign sts_o    = sts_q;
    assign sts_en_o = sts_en_q;
    assign sig_en_o = sig_en_q;
    assign irq_o    = |(sts_q & sig_en_q);

    // R5: a status bit may only rise where an enabled event arrived
    a_r5_no_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt_i & sts_en_q)) == '0));

    // R6: a cleared bit without a simultaneous event is zero next cycle
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts |=> ((sts_q & $past(wdata & ~evt_i)) == '0));

    // R6: an enabled event always wins over a clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_i & sts_en_q) & ~sts_q) == '0));

endmodule

// File: rtl/ecc_launch_fsm.sv
module ecc_launch_fsm
    import ecc_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic go_bit,
    input  logic dir_bit,
    input  logic done_evt,
    output logic start_o,
    output logic busy_o,
    output logic dma_read_o
);

    launch_state_e state_q, state_d;
    logic          dir_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE:   if (ctl_wr && go_bit) state_d = LS_LAUNCH;
            LS_LAUNCH: state_d = done_evt ? LS_IDLE : LS_BUSY;
            LS_BUSY:   if (done_evt) state_d = LS_IDLE;
            default:   state_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    // direction is only accepted while idle
    always_ff @(posedge clk) begin
        if (!rst_n)                            dir_q <= 1'b0;
        else if (ctl_wr && state_q == LS_IDLE) dir_q <= dir_bit;
    end

    always_comb begin
        start_o = 1'b0;
        busy_o  = 1'b0;
        unique case (state_q)
            LS_IDLE:   ;
            LS_LAUNCH: begin start_o = 1'b1; busy_o = 1'b1; end
            LS_BUSY:   busy_o = 1'b1;
            default:   ;
        endcase
    end

    assign dma_read_o = dir_q;

    // R8: the launch pulse lasts a single cycle
    a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R8: busy persists until the completion event
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_evt) |=> busy_o);

    // R9: direction cannot change while a transfer is active
    a_r9_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(dma_read_o));

endmodule

// File: rtl/nand_ecc_csr.sv
module nand_ecc_csr
    import ecc_regs_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          CNT_W        = 8,
    parameter logic [15:0] VERSION      = 16'h0003,
    parameter logic [7:0]  META_BYTES   = 8'd16,
    parameter logic [7:0]  PARITY_BYTES = 8'd10,
    parameter logic [7:0]  RSV_BYTES    = 8'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        evt_i,
    output logic              irq_o,
    output logic              eng_en_o,
    output logic [3:0]        strength_o,
    output logic              burst_incr_o,
    output logic              layout_ilv_o,
    output logic              mem2mem_o,
    output logic              mapping_o,
    output logic [CNT_W-1:0]  chunk_cnt_o,
    output logic [31:0]       main_addr_o,
    output logic [31:0]       spare_addr_o,
    output logic              dma_read_o,
    output logic              start_o
);

    localparam logic [7:0]  SPARE_TOTAL = META_BYTES + PARITY_BYTES + RSV_BYTES;
    localparam logic [31:0] SPARE_WORD  = {SPARE_TOTAL, RSV_BYTES, PARITY_BYTES, META_BYTES};
    localparam logic [31:0] VER_WORD    = {VERSION, 16'h0000};

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic wr_cfg, wr_host, wr_chunks, wr_sts, wr_sts_en, wr_sig_en, wr_ctl;
    logic [1:0] wr_adr;

    always_comb begin
        wr_cfg    = bus_we && hit(bus_addr, OFS_CFG);
        wr_host   = bus_we && hit(bus_addr, OFS_HOST);
        wr_chunks = bus_we && hit(bus_addr, OFS_CHUNKS);
        wr_sts    = bus_we && hit(bus_addr, OFS_STS);
        wr_sts_en = bus_we && hit(bus_addr, OFS_STS_EN);
        wr_sig_en = bus_we && hit(bus_addr, OFS_SIG_EN);
        wr_ctl    = bus_we && hit(bus_addr, OFS_DMA_CTL);
        wr_adr[0] = bus_we && hit(bus_addr, OFS_MAIN_ADR);
        wr_adr[1] = bus_we && hit(bus_addr, OFS_SPARE_ADR);
    end

    logic [1:0][31:0]   adr;
    logic [NUM_EVT-1:0] sts, sts_en, sig_en;
    logic               busy;

    ecc_cfg_bank #(.CNT_W(CNT_W), .ADR_W(32)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cfg     (wr_cfg),
        .wr_host    (wr_host),
        .wr_chunks  (wr_chunks),
        .wr_adr     (wr_adr),
        .wdata      (bus_wdata),
        .eng_en     (eng_en_o),
        .strength   (strength_o),
        .burst_incr (burst_incr_o),
        .layout_ilv (layout_ilv_o),
        .mem2mem    (mem2mem_o),
        .mapping    (mapping_o),
        .chunk_cnt  (chunk_cnt_o),
        .adr        (adr)
    );

    assign main_addr_o  = adr[0];
    assign spare_addr_o = adr[1];

    ecc_irq_unit #(.N(NUM_EVT)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_sts    (wr_sts),
        .wr_sts_en (wr_sts_en),
        .wr_sig_en (wr_sig_en),
        .wdata     (bus_wdata[NUM_EVT-1:0]),
        .sts_o     (sts),
        .sts_en_o  (sts_en),
        .sig_en_o  (sig_en),
        .irq_o     (irq_o)
    );

    ecc_launch_fsm u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (wr_ctl),
        .go_bit     (bus_wdata[DMA_GO_BIT]),
        .dir_bit    (bus_wdata[DMA_RD_BIT]),
        .done_evt   (evt_i[EV_DONE]),
        .start_o    (start_o),
        .busy_o     (busy),
        .dma_read_o (dma_read_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFS_CFG)) begin
            bus_rdata[CFG_EN_BIT]               = eng_en_o;
            bus_rdata[CFG_STR_LSB +: STR_W]     = strength_o;
        end else if (hit(bus_addr, OFS_STS)) begin
            bus_rdata[NUM_EVT-1:0] = sts;
        end else if (hit(bus_addr, OFS_STS_EN)) begin
            bus_rdata[NUM_EVT-1:0] = sts_en;
        end else if (hit(bus_addr, OFS_SIG_EN)) begin
            bus_rdata[NUM_EVT-1:0] = sig_en;
        end else if (hit(bus_addr, OFS_HOST)) begin
            bus_rdata[HOST_BURST] = burst_incr_o;
            bus_rdata[HOST_ILV]   = layout_ilv_o;
            bus_rdata[HOST_M2M]   = mem2mem_o;
            bus_rdata[HOST_MAP]   = mapping_o;
        end else if (hit(bus_addr, OFS_SPARE_LAY)) begin
            bus_rdata = SPARE_WORD;
        end else if (hit(bus_addr, OFS_CHUNKS)) begin
            bus_rdata[CNT_W-1:0] = chunk_cnt_o;
        end else if (hit(bus_addr, OFS_DMA_CTL)) begin
            bus_rdata[DMA_GO_BIT] = busy;
            bus_rdata[DMA_RD_BIT] = dma_read_o;
        end else if (hit(bus_addr, OFS_MAIN_ADR)) begin
            bus_rdata = adr[0];
        end else if (hit(bus_addr, OFS_SPARE_ADR)) begin
            bus_rdata = adr[1];
        end else if (hit(bus_addr, OFS_VERSION)) begin
            bus_rdata = VER_WORD;
        end
    end

    // R7: an event that is both status- and signal-enabled raises the interrupt
    a_r7_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[EV_DONE] && sts_en[EV_DONE] && sig_en[EV_DONE]) |=> irq_o);

    // R8: a start write from idle produces the pulse next cycle
    a_r8_launch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[DMA_GO_BIT] && !busy) |=> start_o);

    // R9: a start write during a transfer produces no pulse
    a_r9_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && busy) |=> !start_o);

endmodule

// File: tb/nand_ecc_csr_test.sv
module nand_ecc_csr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_i = '0;
    logic        irq_o, eng_en_o, burst_incr_o, layout_ilv_o, mem2mem_o, mapping_o;
    logic [3:0]  strength_o;
    logic [7:0]  chunk_cnt_o;
    logic [31:0] main_addr_o, spare_addr_o;
    logic        dma_read_o, start_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nand_ecc_csr uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .irq_o(irq_o), .eng_en_o(eng_en_o), .strength_o(strength_o),
        .burst_incr_o(burst_incr_o), .layout_ilv_o(layout_ilv_o),
        .mem2mem_o(mem2mem_o), .mapping_o(mapping_o),
        .chunk_cnt_o(chunk_cnt_o), .main_addr_o(main_addr_o),
        .spare_addr_o(spare_addr_o), .dma_read_o(dma_read_o), .start_o(start_o)
    );

    // {addr, write data, expected read-back, requirement number}
    localparam int NV = 13;
    localparam logic [75:0] VEC [0:NV-1] = '{
        {8'h00, 32'hFFFF_FFFF, 32'h0000_0079, 4'd2},   // R2 all ones
        {8'h00, 32'h0000_0028, 32'h0000_0028, 4'd2},   // R2 strength 5
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0035, 4'd3},   // R3 all flags
        {8'h10, 32'h0000_0014, 32'h0000_0014, 4'd3},   // R3 interleave + m2m
        {8'h30, 32'hFFFF_FFFF, 32'h0000_00FF, 4'd4},   // R4 chunk count
        {8'h44, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd4},   // R4 main address
        {8'h48, 32'h1234_5678, 32'h1234_5678, 4'd4},   // R4 spare address
        {8'h08, 32'hFFFF_FFFF, 32'h0000_003F, 4'd5},   // R5 status mask
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_003F, 4'd7},   // R7 signal mask
        {8'h28, 32'hFFFF_FFFF, 32'h2006_0A10, 4'd10},  // R10 spare layout
        {8'hD0, 32'hFFFF_FFFF, 32'h0003_0000, 4'd10},  // R10 version
        {8'h3C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd11},  // R11 unmapped
        {8'h20, 32'hFFFF_FFFF, 32'h0000_0000, 4'd11}   // R11 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [5:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        foreach (VEC[i]) begin
            if (VEC[i][3:0] != 4'd10) begin
                rd(VEC[i][75:68], r);
                check("R1 reset read", r, 32'h0);
            end
        end
        rd(8'h04, r); check("R1 reset status", r, 32'h0);
        rd(8'h40, r); check("R1 reset dma ctl", r, 32'h0);
        check("R1 reset irq", {31'b0, irq_o}, 32'h0);
        check("R1 reset start", {31'b0, start_o}, 32'h0);

        // table walk: write, then read back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][75:68], VEC[i][67:36]);
            rd(VEC[i][75:68], r);
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), r, VEC[i][35:4]);
        end

        // outputs driven by stored fields
        check("R2 eng_en", {31'b0, eng_en_o}, 32'h0);
        check("R2 strength", {28'b0, strength_o}, 32'h5);
        check("R3 flags", {28'b0, mapping_o, mem2mem_o, layout_ilv_o, burst_incr_o}, 32'h6);
        check("R4 chunk out", {24'b0, chunk_cnt_o}, 32'hFF);
        check("R4 main out", main_addr_o, 32'hDEAD_BEEF);
        check("R4 spare out", spare_addr_o, 32'h1234_5678);

        // R5 masked events do not latch
        wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
        pulse_evt(6'h3F);
        rd(8'h04, r); check("R5 masked events", r, 32'h0);
        wr(8'h08, 32'h3F);
        pulse_evt(6'h2A);
        rd(8'h04, r); check("R5 enabled events", r, 32'h2A);
        check("R7 irq with no signal enable", {31'b0, irq_o}, 32'h0);
        wr(8'h0C, 32'h01);
        check("R7 irq non-matching enable", {31'b0, irq_o}, 32'h0);
        wr(8'h0C, 32'h08);
        check("R7 irq matching enable", {31'b0, irq_o}, 32'h1);

        // R6 write-1-to-clear
        wr(8'h04, 32'h08);
        rd(8'h04, r); check("R6 clear one bit", r, 32'h22);
        check("R7 irq drops after clear", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h20; bus_we = 1'b1; evt_i = 6'h20;
        @(negedge clk);
        bus_we = 1'b0; evt_i = '0;
        rd(8'h04, r); check("R6 set wins over clear", r, 32'h22);
        wr(8'h04, 32'h0);
        rd(8'h04, r); check("R6 zero write keeps bits", r, 32'h22);
        wr(8'h04, 32'h22);
        rd(8'h04, r); check("R6 write back clears", r, 32'h0);

        // R8 launch
        wr(8'h40, 32'h8000_0002);
        check("R8 start pulse", {31'b0, start_o}, 32'h1);
        check("R8 direction read", {31'b0, dma_read_o}, 32'h1);
        rd(8'h40, r); check("R8 busy readback", r, 32'h8000_0002);
        @(negedge clk);
        check("R8 pulse one cycle", {31'b0, start_o}, 32'h0);
        rd(8'h40, r); check("R8 still busy", r, 32'h8000_0002);

        // R9 writes while busy ignored
        wr(8'h40, 32'h8000_0000);
        check("R9 no relaunch", {31'b0, start_o}, 32'h0);
        rd(8'h40, r); check("R9 direction held", r, 32'h8000_0002);

        // completion
        pulse_evt(6'h01);
        rd(8'h40, r); check("R8 start self-clears", r, 32'h0000_0002);
        rd(8'h04, r); check("R5 transfer complete latched", r, 32'h01);

        // R9 idle write without start bit
        wr(8'h40, 32'h0);
        check("R9 no pulse without start bit", {31'b0, start_o}, 32'h0);
        rd(8'h40, r); check("R9 direction update", r, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule